// File: doc/BRIEF.md
# Synchronous Serial Position Transmitter (Sensor Side)

This block is the sensor end of a synchronous serial position link. A controller drives a slow serial clock line; the block answers on a single serial data line. Between reads the data line rests high and an internal holding register keeps taking the newest position word offered on a valid/ready input stream. The first falling edge of the serial clock after a rest period freezes that word. Each rising edge then shifts one bit out, most significant bit first. One extra rising edge after the last data bit drives a trailing bit. That bit is low, or it is the latched error flag when the error option is built in.

A retriggerable timeout decides what happens next. The timeout counts system clock cycles and restarts on every serial clock edge. If the clock keeps running, the timeout never expires and the same frozen word is sent again from its most significant bit. If the clock line stays high for longer than the timeout, the block drops any partial frame, drives the line high again and goes back to accepting position words. The serial clock is asynchronous to the system clock, so it passes through a two-stage synchronizer, and its edges are found in the system clock domain. Every serial edge therefore reaches the data line three system clock cycles later.

The position input is a stream. `pos_ready_o` is high only while the block is resting. A word is taken on any cycle where both `pos_valid_i` and `pos_ready_o` are high. While a read is in progress, ready is low and the offered word stays with the producer. Words offered with valid low, or while ready is low, change nothing.

Top module: `ssi_slave_tx`

## Requirements
- R1: After reset, `sdata_o` is 1 and `pos_ready_o` is 1.
- R2: While resting, `pos_ready_o` is 1 and the holding register takes `{pos_err_i, pos_data_i}` on every cycle where `pos_valid_i` is 1. Inputs seen with `pos_valid_i` at 0 have no effect on the next transmitted word.
- R3: A falling serial clock edge while resting freezes the held word and makes `pos_ready_o` 0. `sdata_o` stays 1 until the first rising edge. Words offered during a read are not taken.
- R4: Rising edge k of a pass (k = 1..N) drives bit N-k of the frozen word, so the most significant bit goes first.
- R5: Rising edge N+1 of a pass drives the trailing bit, which is held until the next edge or the timeout. The trailing bit is the frozen error flag when ERR_EN=1, and 0 when ERR_EN=0.
- R6: A rising edge after the trailing bit, arriving before the timeout expires, restarts the same frozen word from its most significant bit. Its value is not reloaded.
- R7: Once the serial clock has stayed high for more than TIMEOUT system cycles during a read, the block returns to rest: `sdata_o` goes to 1 and `pos_ready_o` goes to 1. This aborts any partial pass.
- R8: `sdata_o` changes only in the cycle after a detected rising serial edge or a timeout. A serial edge takes effect three system cycles after the input changes.
- R9: The timeout restarts on every serial clock edge, so clocking with half periods shorter than TIMEOUT cycles never ends a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock from the controller, asynchronous, rests high |
| pos_data_i | input | N | Position word offered on the input stream |
| pos_err_i | input | 1 | Error flag that travels with the position word |
| pos_valid_i | input | 1 | Input stream valid |
| pos_ready_o | output | 1 | Input stream ready, high only while resting |
| sdata_o | output | 1 | Serial data line to the controller, rests high |

## Verification
The bench compares two builds side by side, one with the error option and one without. If the trailing bit were routed wrongly, the two builds would disagree with their expected values on rising edge N+1. Reads run for up to three passes, to catch a design that reloads on a repeat pass or restarts from the wrong bit. Other reads are cut short at a random bit and then followed by a full read, to catch a design that resumes mid-word after a timeout. One read uses half periods just under the timeout, to catch a counter that is not restarted on every edge. Junk words are offered with valid low, and again during a read with valid high. A design that ignored the handshake would then send the junk instead of the held word.

// File: rtl/ssi_pkg.sv
package ssi_pkg;

  // Read-cycle state of the transmitter
  typedef enum logic {
    ST_REST   = 1'b0,
    ST_ACTIVE = 1'b1
  } ssi_state_e;

  // Counter width able to hold values 0..max_val
  function automatic int cnt_width(input int max_val);
    int w;
    w = 1;
    while ((1 << w) <= max_val) w++;
    return w;
  endfunction

endpackage

// File: rtl/ssi_edge_sync.sv
module ssi_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);

  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  // Chain resets to 1, the resting level of the serial clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], line_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign level_o = sync_q[STAGES-1];
  assign rise_o  = level_o & ~prev_q;
  assign fall_o  = ~level_o & prev_q;

  // R8: an edge pulse lasts exactly one system cycle
  a_r8_edge_single: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);

  // R8: rising and falling pulses never coincide
  a_r8_edge_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_o && fall_o));

endmodule

// File: rtl/ssi_monoflop.sv
module ssi_monoflop #(
  parameter int TIMEOUT = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  output logic expired_o
);
  import ssi_pkg::*;

  localparam int CW = cnt_width(TIMEOUT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (restart_i) begin
      cnt_q <= CW'(TIMEOUT);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired_o = (cnt_q == '0);

  // R9: every serial edge reloads the full timeout
  a_r9_reload: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (cnt_q == CW'(TIMEOUT)));

  // R9: without an edge the count only moves down by one
  a_r9_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/ssi_frame_shifter.sv
module ssi_frame_shifter #(
  parameter int N      = 16,
  parameter bit ERR_EN = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pos_i,
  input  logic         err_i,
  input  logic         pos_valid_i,
  output logic         pos_ready_o,
  input  logic         rise_i,
  input  logic         fall_i,
  input  logic         timeout_i,
  output logic         active_o,
  output logic         dout_o
);
  import ssi_pkg::*;

  localparam int BW = cnt_width(N);

  ssi_state_e   state_q;
  logic [N-1:0] hold_q;
  logic         hold_err_q;
  logic [N-1:0] frozen_q;
  logic         frozen_err_q;
  logic [N-1:0] work_q;
  logic [BW-1:0] sent_q;
  logic         dout_q;
  logic         trail_bit;

  generate
    if (ERR_EN) begin : g_flag
      assign trail_bit = frozen_err_q;
    end else begin : g_noflag
      assign trail_bit = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_REST;
      hold_q       <= '0;
      hold_err_q   <= 1'b0;
      frozen_q     <= '0;
      frozen_err_q <= 1'b0;
      work_q       <= '0;
      sent_q       <= '0;
      dout_q       <= 1'b1;
    end else begin
      case (state_q)
        ST_REST: begin
          dout_q <= 1'b1;
          if (pos_valid_i) begin
            hold_q     <= pos_i;
            hold_err_q <= err_i;
          end
          if (fall_i) begin
            frozen_q     <= hold_q;
            frozen_err_q <= hold_err_q;
            work_q       <= hold_q;
            sent_q       <= '0;
            state_q      <= ST_ACTIVE;
          end
        end
        default: begin
          if (timeout_i) begin
            state_q <= ST_REST;
            dout_q  <= 1'b1;
          end else if (rise_i) begin
            if (sent_q == BW'(N)) begin
              // trailing bit, then rearm the same word for a repeat pass
              dout_q <= trail_bit;
              work_q <= frozen_q;
              sent_q <= '0;
            end else begin
              dout_q <= work_q[N-1];
              work_q <= work_q << 1;
              sent_q <= sent_q + 1'b1;
            end
          end
        end
      endcase
    end
  end

  assign pos_ready_o = (state_q == ST_REST);
  assign active_o    = (state_q == ST_ACTIVE);
  assign dout_o      = dout_q;

  // R3/R6: the frozen word never changes during a read
  a_r3_frozen_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && $past(active_o)) |-> $stable(frozen_q));

  // R3: the holding register is locked while a read runs
  a_r3_hold_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && $past(active_o)) |-> $stable(hold_q));

  // R5: the pass position never exceeds N
  a_r5_sent_range: assert property (@(posedge clk) disable iff (!rst_n)
    sent_q <= BW'(N));

  // R3: a fall while resting starts a read with the line still high
  a_r3_start_high: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_o && fall_i) |=> (active_o && dout_o));

endmodule

// File: rtl/ssi_slave_tx.sv
module ssi_slave_tx #(
  parameter int N       = 16,
  parameter int TIMEOUT = 200,
  parameter bit ERR_EN  = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sclk_i,
  input  logic [N-1:0] pos_data_i,
  input  logic         pos_err_i,
  input  logic         pos_valid_i,
  output logic         pos_ready_o,
  output logic         sdata_o
);

  logic sclk_level;
  logic sclk_rise;
  logic sclk_fall;
  logic mono_expired;
  logic active;
  logic expire;

  ssi_edge_sync #(.STAGES(2)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .line_i  (sclk_i),
    .level_o (sclk_level),
    .rise_o  (sclk_rise),
    .fall_o  (sclk_fall)
  );

  ssi_monoflop #(.TIMEOUT(TIMEOUT)) u_mono (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (sclk_rise | sclk_fall),
    .expired_o (mono_expired)
  );

  // Only a long high phase ends a read
  assign expire = active & sclk_level & mono_expired & ~sclk_rise & ~sclk_fall;

  ssi_frame_shifter #(.N(N), .ERR_EN(ERR_EN)) u_shift (
    .clk         (clk),
    .rst_n       (rst_n),
    .pos_i       (pos_data_i),
    .err_i       (pos_err_i),
    .pos_valid_i (pos_valid_i),
    .pos_ready_o (pos_ready_o),
    .rise_i      (sclk_rise),
    .fall_i      (sclk_fall),
    .timeout_i   (expire),
    .active_o    (active),
    .dout_o      (sdata_o)
  );

  // R7: a resting transmitter holds the line high
  a_r7_rest_high: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> sdata_o);

  // R7: a timeout returns the block to rest and reopens the stream
  a_r7_timeout_rest: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (pos_ready_o && sdata_o));

  // R8: the line moves only after a rising edge or a timeout
  a_r8_line_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(sclk_rise || expire) |=> $stable(sdata_o));

  // R2: ready is never low while resting
  a_r2_ready_rest: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> pos_ready_o);

endmodule

// File: tb/tb_ssi_slave_tx.sv
module tb_ssi_slave_tx;

  localparam int N  = 12;
  localparam int TO = 40;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         sclk = 1'b1;
  logic [N-1:0] pos = '0;
  logic         perr = 1'b0;
  logic         pvalid = 1'b0;
  logic         ready_f, sdata_f, ready_p, sdata_p;

  int n_chk = 0;
  int n_fail = 0;
  int hp = 6;
  logic [N-1:0] last_word = '0;
  logic         last_err = 1'b0;

  always #5 clk = ~clk;

  ssi_slave_tx #(.N(N), .TIMEOUT(TO), .ERR_EN(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .pos_data_i(pos),
    .pos_err_i(perr), .pos_valid_i(pvalid), .pos_ready_o(ready_f), .sdata_o(sdata_f)
  );

  ssi_slave_tx #(.N(N), .TIMEOUT(TO), .ERR_EN(1'b0)) dut_plain (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .pos_data_i(pos),
    .pos_err_i(perr), .pos_valid_i(pvalid), .pos_ready_o(ready_p), .sdata_o(sdata_p)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic exp_bit(input logic [N-1:0] w, input logic e,
                                   input int k, input bit flag_en);
    int idx;
    idx = (k - 1) % (N + 1);
    if (idx < N) return w[N-1-idx];
    return flag_en ? e : 1'b0;
  endfunction

  task automatic half(input logic lvl);
    @(negedge clk);
    sclk = lvl;
    repeat (hp - 1) @(negedge clk);
  endtask

  // present: offer a fresh word; nrise: rising edges before the clock stops
  task automatic run_frame(input logic [N-1:0] w, input logic e,
                           input bit present, input int nrise);
    logic [N-1:0] ew;
    logic         ee;
    @(negedge clk);
    if (present) begin
      pos = w; perr = e; pvalid = 1'b1;
      repeat (3) @(negedge clk);
      last_word = w; last_err = e;
    end
    // R2: junk with valid low must not reach the holding register
    pvalid = 1'b0; pos = ~last_word ^ N'($urandom); perr = ~last_err;
    repeat (2) @(negedge clk);
    ew = last_word; ee = last_err;
    check("R2 ready while resting", ready_f, 1'b1);
    half(1'b0);
    check("R3 line high after freeze", sdata_f, 1'b1);
    check("R3 ready low during read", ready_f, 1'b0);
    // R3: words offered during a read are refused
    pvalid = 1'b1; pos = N'($urandom); perr = ~ee;
    for (int k = 1; k <= nrise; k++) begin
      half(1'b1);
      if (k == 1) pvalid = 1'b0;
      if (((k - 1) % (N + 1)) == N) begin
        check("R5 trailing flag", sdata_f, exp_bit(ew, ee, k, 1'b1));
        check("R5 trailing low", sdata_p, exp_bit(ew, ee, k, 1'b0));
      end else if (k > N) begin
        check("R6 repeat pass bit", sdata_f, exp_bit(ew, ee, k, 1'b1));
      end else begin
        check("R4 data bit", sdata_f, exp_bit(ew, ee, k, 1'b1));
        check("R4 data bit plain", sdata_p, exp_bit(ew, ee, k, 1'b0));
      end
      if (k < nrise) half(1'b0);
    end
    if (nrise == 0) begin
      @(negedge clk); sclk = 1'b1; pvalid = 1'b0;
    end
    repeat (TO + 20) @(negedge clk);
    check("R7 line high after timeout", sdata_f, 1'b1);
    check("R7 ready after timeout", ready_f, 1'b1);
    check("R7 plain ready after timeout", ready_p, 1'b1);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    check("R1 reset line", sdata_f, 1'b1);
    check("R1 reset ready", ready_f, 1'b1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 line after reset", sdata_f, 1'b1);

    // R4/R5: one full pass with flag set, then flag clear
    run_frame(12'hA5C, 1'b1, 1'b1, N + 1);
    run_frame(12'h801, 1'b0, 1'b1, N + 1);
    // R6: three passes of the same word under continuous clocking
    run_frame(12'h3C7, 1'b1, 1'b1, 3 * (N + 1));
    // R7: abort mid-word, then a full read starts again from the MSB
    run_frame(12'hFFF, 1'b1, 1'b1, 5);
    run_frame(12'h000, 1'b0, 1'b1, N + 2);
    // R2: no fresh word offered, the held word is sent again
    run_frame(12'h555, 1'b1, 1'b0, N + 1);
    // R9: half periods just under the timeout keep the read alive
    hp = TO - 8;
    run_frame(12'h6B2, 1'b1, 1'b1, N + 3);
    hp = 6;
    // R7: fall followed by no rising edge at all
    run_frame(12'h123, 1'b0, 1'b1, 0);
    run_frame(12'hABC, 1'b1, 1'b1, N + 1);

    for (int i = 0; i < 12; i++) begin
      logic [N-1:0] w;
      int nr;
      w  = N'($urandom);
      nr = 1 + int'($urandom % (2 * (N + 1) + 2));
      hp = 4 + int'($urandom % 8);
      run_frame(w, 1'($urandom), ($urandom % 4) != 0, nr);
    end
    finish_run();
  end

endmodule